// File: doc/BRIEF.md
# Paged CSR Window Decoder

This block decodes a 4 KB control/status register aperture that is reached over a simple memory-mapped bus. The lower three quarters of the aperture (byte offsets 0x000 to 0xBFF) map one to one onto the same logical offsets. The top quarter (0xC00 to 0xFFF) is a 1 KB window into a larger logical register space. A bank field inside a control register selects which 1 KB of that space the window shows, so one window reaches up to 64 KB of logical registers. Every access is checked for size and alignment before it touches any state.

Each bus access becomes a flat logical word address, a set of byte lanes and a pass/fail verdict. These then drive a backing word array. The control register is held in its own flops and always sits at the same logical offset. It is therefore reached both at its direct offset and through the window while bank 0 is selected. Data on the 32-bit bus is lane-aligned: a byte or halfword travels in the lanes that its address selects.

A three-state controller sequences each transfer:
- **ST_IDLE** accepts a request when either enable is high. If both enables are high, the write is taken.
- The **accept** transition captures the translated request and moves to **ST_EXEC**.
- **ST_EXEC** performs the array or control write, or the registered array read.
- The **execute** transition always moves to **ST_DONE**.
- **ST_DONE** presents the response for one cycle.
- The **retire** transition returns to **ST_IDLE**.

The bus master waits for the response before it issues the next request.

Top module: `pcw_decoder`

## Requirements
- R1: Aperture offsets below 0xC00 reach the logical register at the same offset, whatever value the bank field holds.
- R2: Aperture offsets 0xC00 to 0xFFF reach logical byte offset {bank, addr[9:0]}, with the bank supplying logical bits [15:10].
- R3: The control register is at direct offset 0x080. All 32 of its bits are stored and read back unchanged. Bits [18:13] form the bank field. With bank 0 it is also reachable through the window at 0xC80.
- R4: After reset the whole control register, including the bank field, reads zero, and no response outputs are active.
- R5: Size code 0 is a byte, 1 is a halfword and 2 is a word. Writes update only the addressed lanes. Reads return the addressed lanes in place, with all other lanes zero.
- R6: Size code 3 is rejected. A rejected access raises the error flag, a rejected read returns zero, and a rejected write changes no register and leaves the bank field as it was.
- R7: A halfword at an odd address, or a word whose address[1:0] is not zero, is rejected in the same way as R6.
- R8: The read-valid or write-acknowledge pulse lasts exactly one cycle and comes in the second cycle after the request is accepted. The error flag is high only together with that pulse.
- R9: A write to the bank field steers the very next bus access into the window, with no wait cycles.
- R10: Logical words at or above the implemented store depth (8 KB by default, banks 0 to 7) read as zero and discard writes without error. They never alias onto lower words.
- R11: A request presented while a transfer is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the aperture |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_wdata | input | 32 | Lane-aligned write data |
| bus_rdata | output | 32 | Lane-aligned read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response pulse |
| bus_wack | output | 1 | Write acknowledge pulse |
| bus_err | output | 1 | Rejected-access flag, with the response pulse |

## Verification
The bench builds the block with its default parameters: a 6-bit bank field at bits [18:13], the control register at 0x080, and an 11-bit word store covering banks 0 to 7. Because the store covers only eight banks, bank 9 reaches unimplemented space. Its window offset 0x020 would wrap onto direct offset 0x420 if the upper logical bits were dropped, so the bench can observe that alias directly. Bank 1 makes the window overlap the direct registers at 0x400. Bank 0 exposes the control register at 0xC80. Both overlaps let the bench check window translation against direct accesses.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } fsm_e;

    localparam int LANES = 4;

    function automatic logic [31:0] lane_mask(input logic [LANES-1:0] strb);
        logic [31:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[8*i +: 8] = {8{strb[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/pcw_xlate.sv
module pcw_xlate
    import pcw_pkg::*;
#(
    parameter int APER_AW = 12,
    parameter int WIN_AW  = 10,
    parameter int PAGE_W  = 6,
    localparam int LOG_WAW = PAGE_W + WIN_AW - 2
) (
    input  logic [APER_AW-1:0] addr,
    input  xfer_size_e         size,
    input  logic [PAGE_W-1:0]  page,
    output logic [LOG_WAW-1:0] waddr,
    output logic [LANES-1:0]   strb,
    output logic               ok
);
    localparam int WIN_BASE = (2 ** APER_AW) - (2 ** WIN_AW);

    logic in_win;
    logic aligned;

    assign in_win = (int'(addr) >= WIN_BASE);

    // Window hits take the bank as the top logical bits; direct hits pass through.
    always_comb begin
        if (in_win) begin
            waddr = {page, addr[WIN_AW-1:2]};
        end else begin
            waddr = LOG_WAW'(addr[APER_AW-1:2]);
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                strb    = 4'b0001 << addr[1:0];
                aligned = 1'b1;
            end
            SZ_HALF: begin
                strb    = 4'b0011 << addr[1:0];
                aligned = ~addr[0];
            end
            SZ_WORD: begin
                strb    = 4'b1111;
                aligned = (addr[1:0] == 2'b00);
            end
            default: begin
                strb    = 4'b0000;
                aligned = 1'b0;
            end
        endcase
    end

    assign ok = aligned;

endmodule

// File: rtl/pcw_store.sv
module pcw_store
    import pcw_pkg::*;
#(
    parameter int LOG_WAW    = 14,
    parameter int STORE_AW   = 11,
    parameter int CTRL_WADDR = 'h20,
    parameter int PAGE_LSB   = 13,
    parameter int PAGE_W     = 6,
    localparam int DEPTH     = 2 ** STORE_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               re,
    input  logic [LOG_WAW-1:0] waddr,
    input  logic [LANES-1:0]   strb,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic [PAGE_W-1:0]  page
);
    logic [31:0] mem [DEPTH];
    logic [31:0] ctrl_q;
    logic        hit_ctrl;
    logic        in_range;

    assign hit_ctrl = (waddr == LOG_WAW'(CTRL_WADDR));

    generate
        if (STORE_AW < LOG_WAW) begin : g_partial
            assign in_range = (waddr[LOG_WAW-1:STORE_AW] == '0);
        end else begin : g_full
            assign in_range = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && hit_ctrl) begin
            for (int i = 0; i < LANES; i++) begin
                if (strb[i]) ctrl_q[8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (we && in_range && !hit_ctrl) begin
            for (int i = 0; i < LANES; i++) begin
                if (strb[i]) mem[waddr[STORE_AW-1:0]][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            if (hit_ctrl)      rdata <= ctrl_q;
            else if (in_range) rdata <= mem[waddr[STORE_AW-1:0]];
            else               rdata <= '0;
        end
    end

    assign page = ctrl_q[PAGE_LSB +: PAGE_W];

endmodule

// File: rtl/pcw_decoder.sv
module pcw_decoder
    import pcw_pkg::*;
#(
    parameter int APER_AW   = 12,
    parameter int WIN_AW    = 10,
    parameter int PAGE_W    = 6,
    parameter int PAGE_LSB  = 13,
    parameter int CTRL_OFFS = 'h080,
    parameter int STORE_AW  = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [APER_AW-1:0] bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [1:0]         bus_size,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic               bus_wack,
    output logic               bus_err
);
    localparam int LOG_WAW    = PAGE_W + WIN_AW - 2;
    localparam int CTRL_WADDR = CTRL_OFFS / 4;

    fsm_e               state_q, state_d;
    logic               accept;
    logic [PAGE_W-1:0]  page;
    logic [LOG_WAW-1:0] x_waddr;
    logic [LANES-1:0]   x_strb;
    logic               x_ok;

    logic               cap_wr;
    logic               cap_err;
    logic [LOG_WAW-1:0] cap_waddr;
    logic [LANES-1:0]   cap_strb;
    logic [31:0]        cap_wdata;

    logic               store_we;
    logic               store_re;
    logic [31:0]        store_rdata;

    pcw_xlate #(
        .APER_AW(APER_AW),
        .WIN_AW (WIN_AW),
        .PAGE_W (PAGE_W)
    ) u_xlate (
        .addr (bus_addr),
        .size (xfer_size_e'(bus_size)),
        .page (page),
        .waddr(x_waddr),
        .strb (x_strb),
        .ok   (x_ok)
    );

    pcw_store #(
        .LOG_WAW   (LOG_WAW),
        .STORE_AW  (STORE_AW),
        .CTRL_WADDR(CTRL_WADDR),
        .PAGE_LSB  (PAGE_LSB),
        .PAGE_W    (PAGE_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (store_we),
        .re   (store_re),
        .waddr(cap_waddr),
        .strb (cap_strb),
        .wdata(cap_wdata),
        .rdata(store_rdata),
        .page (page)
    );

    assign accept = (state_q == ST_IDLE) && (bus_wr || bus_rd);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, execute, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request capture, translated with the bank in force at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_wr    <= 1'b0;
            cap_err   <= 1'b0;
            cap_waddr <= '0;
            cap_strb  <= '0;
            cap_wdata <= '0;
        end else if (accept) begin
            cap_wr    <= bus_wr;
            cap_err   <= ~x_ok;
            cap_waddr <= x_waddr;
            cap_strb  <= x_strb;
            cap_wdata <= bus_wdata;
        end
    end

    // Outputs
    always_comb begin
        store_we   = 1'b0;
        store_re   = 1'b0;
        bus_rvalid = 1'b0;
        bus_wack   = 1'b0;
        bus_err    = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_EXEC: begin
                store_we = cap_wr && !cap_err;
                store_re = !cap_wr && !cap_err;
            end
            ST_DONE: begin
                bus_rvalid = !cap_wr;
                bus_wack   = cap_wr;
                bus_err    = cap_err;
                if (!cap_wr && !cap_err) bus_rdata = store_rdata & lane_mask(cap_strb);
            end
            default: ;
        endcase
    end

    AST_ERR_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rvalid || bus_wack)); // R8
    AST_ONE_RESP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rvalid, bus_wack})); // R8
    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 (bus_rvalid || bus_wack)); // R8
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid || bus_wack) |=> !(bus_rvalid || bus_wack)); // R8
    AST_REJECT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rvalid && bus_err) |-> (bus_rdata == '0)); // R6
    AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !store_we |=> $stable(page)); // R6
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC) |=> (state_q == ST_DONE)); // R11

endmodule

// File: tb/pcw_decoder_test.sv
module pcw_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        bus_wack;
    logic        bus_err;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcw_decoder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid),
        .bus_wack  (bus_wack),
        .bus_err   (bus_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output int lat);
        @(negedge clk);
        bus_wr = wr; bus_rd = ~wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        lat = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            lat++;
            if (bus_rvalid || bus_wack) break;
        end
        rd = bus_rdata;
        er = bus_err;
    endtask

    task automatic wr_ok(input string req, input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] wd);
        logic [31:0] rd; logic er; int lat;
        xfer(1'b1, a, sz, wd, rd, er, lat);
        check(req, "write error flag", 32'(er), 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] exp);
        logic [31:0] rd; logic er; int lat;
        xfer(1'b0, a, sz, 32'h0, rd, er, lat);
        check(req, $sformatf("read data @%h", a), rd, exp);
        check(req, "read error flag", 32'(er), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R4", "idle response outputs", {bus_rdata[28:0], bus_rvalid, bus_wack, bus_err}, 32'd0);
        rd_chk("R4", 12'h080, 2'd2, 32'h0000_0000);
    endtask

    task automatic t_direct;
        wr_ok("R1", 12'h400, 2'd2, 32'h1122_3344);
        wr_ok("R1", 12'hBFC, 2'd2, 32'hCAFE_F00D);
        wr_ok("R1", 12'h420, 2'd2, 32'h0BAD_F00D);
        rd_chk("R1", 12'h400, 2'd2, 32'h1122_3344);
        rd_chk("R1", 12'hBFC, 2'd2, 32'hCAFE_F00D);
    endtask

    task automatic t_window;
        wr_ok("R3", 12'h080, 2'd2, 32'hA500_2011);          // bank 1
        rd_chk("R9", 12'hC00, 2'd2, 32'h1122_3344);         // next access uses bank 1 -> logical 0x400
        rd_chk("R3", 12'h080, 2'd2, 32'hA500_2011);
        wr_ok("R2", 12'hC04, 2'd2, 32'h5566_7788);          // logical 0x404
        wr_ok("R3", 12'h080, 2'd2, 32'hA500_A011);          // bank 5
        rd_chk("R1", 12'hBFC, 2'd2, 32'hCAFE_F00D);         // direct ignores bank
        wr_ok("R2", 12'hC10, 2'd2, 32'hDEAD_BEEF);          // logical 0x1410
        wr_ok("R3", 12'h080, 2'd2, 32'hA500_0011);          // bank 0
        rd_chk("R2", 12'h404, 2'd2, 32'h5566_7788);
        rd_chk("R3", 12'hC80, 2'd2, 32'hA500_0011);         // control alias through window
        wr_ok("R9", 12'h080, 2'd2, 32'hA500_A011);          // bank 5 again
        rd_chk("R9", 12'hC10, 2'd2, 32'hDEAD_BEEF);
    endtask

    task automatic t_beyond_store;
        wr_ok("R10", 12'h080, 2'd2, 32'h0001_2000);         // bank 9
        wr_ok("R10", 12'hC20, 2'd2, 32'h1234_5678);
        rd_chk("R10", 12'hC20, 2'd2, 32'h0000_0000);
        rd_chk("R10", 12'h420, 2'd2, 32'h0BAD_F00D);        // no wrap onto 0x420
        wr_ok("R10", 12'h080, 2'd2, 32'h0000_0000);
    endtask

    task automatic t_subword;
        wr_ok("R5", 12'h200, 2'd2, 32'hAABB_CCDD);
        wr_ok("R5", 12'h201, 2'd0, 32'h0000_EE00);
        rd_chk("R5", 12'h200, 2'd2, 32'hAABB_EEDD);
        wr_ok("R5", 12'h202, 2'd1, 32'h1234_0000);
        rd_chk("R5", 12'h200, 2'd2, 32'h1234_EEDD);
        rd_chk("R5", 12'h203, 2'd0, 32'h1200_0000);
        rd_chk("R5", 12'h200, 2'd1, 32'h0000_EEDD);
    endtask

    task automatic t_bad_size;
        logic [31:0] rd; logic er; int lat;
        xfer(1'b1, 12'h200, 2'd3, 32'hFFFF_FFFF, rd, er, lat);
        check("R6", "bad size write error", 32'(er), 32'd1);
        xfer(1'b0, 12'h200, 2'd3, 32'h0, rd, er, lat);
        check("R6", "bad size read error", 32'(er), 32'd1);
        check("R6", "bad size read data", rd, 32'h0);
        rd_chk("R6", 12'h200, 2'd2, 32'h1234_EEDD);
    endtask

    task automatic t_misaligned;
        logic [31:0] rd; logic er; int lat;
        xfer(1'b1, 12'h201, 2'd2, 32'hFFFF_FFFF, rd, er, lat);
        check("R7", "word at +1 error", 32'(er), 32'd1);
        xfer(1'b1, 12'h203, 2'd1, 32'hFFFF_FFFF, rd, er, lat);
        check("R7", "half at +3 error", 32'(er), 32'd1);
        xfer(1'b0, 12'h202, 2'd2, 32'h0, rd, er, lat);
        check("R7", "word read at +2 error", 32'(er), 32'd1);
        check("R7", "word read at +2 data", rd, 32'h0);
        rd_chk("R7", 12'h200, 2'd2, 32'h1234_EEDD);
        xfer(1'b1, 12'h081, 2'd2, 32'hFFFF_FFFF, rd, er, lat);
        check("R7", "misaligned control write error", 32'(er), 32'd1);
        rd_chk("R7", 12'h080, 2'd2, 32'h0000_0000);
    endtask

    task automatic t_timing;
        logic [31:0] rd; logic er; int lat;
        xfer(1'b0, 12'h400, 2'd2, 32'h0, rd, er, lat);
        check("R8", "read latency cycles", 32'(lat), 32'd1);
        check("R8", "read valid level", 32'(bus_rvalid), 32'd1);
        @(negedge clk);
        check("R8", "response after pulse", {29'd0, bus_rvalid, bus_wack, bus_err}, 32'd0);
        xfer(1'b1, 12'h200, 2'd3, 32'h0, rd, er, lat);
        check("R8", "error write latency", 32'(lat), 32'd1);
        check("R8", "error with ack", {30'd0, bus_wack, bus_err}, 32'd3);
        @(negedge clk);
        check("R8", "error after pulse", {29'd0, bus_rvalid, bus_wack, bus_err}, 32'd0);
    endtask

    task automatic t_busy;
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = 12'h200; bus_size = 2'd2;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b1; bus_wdata = 32'h9999_9999;   // arrives while busy
        @(negedge clk);
        check("R11", "in-flight read data", bus_rdata, 32'h1234_EEDD);
        check("R11", "in-flight response kind", {30'd0, bus_rvalid, bus_wack}, 32'd2);
        bus_wr = 1'b0;
        rd_chk("R11", 12'h200, 2'd2, 32'h1234_EEDD);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL R8 watchdog: actual=hung expected=complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_window();
        t_beyond_store();
        t_subword();
        t_bad_size();
        t_misaligned();
        t_timing();
        t_busy();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule